// File: doc/BRIEF.md
# Three-Phase Complementary Dead-Time PWM Timer

This timer drives three phase pairs for a bridge inverter. Each pair has a high-side output and a low-side output. A triangular carrier is produced by two up/down counters that run in lockstep. The reference counter starts from zero and turns at the half-carrier value. The offset counter starts from the dead-time value and turns at dead time plus half carrier. Each phase compares its duty value against both counters. The result is a pair of outputs that never overlap, with a gap of exactly the dead time on every switching edge.

Duty values and the half-carrier value are normally updated through buffer registers. A buffer write stages the value in a hidden temporary register, and the live register picks it up only at a carrier turning point. A carrier period therefore never mixes old and new settings. An access-enable input fences off the live registers from the bus, while the buffers stay open. A read-only dead-time subcounter shows how far the current gap has run.

Top module: `tri_pwm_deadtime`

## Requirements
- R1: After reset all phase outputs and `cyc_stb` are low, the dead time reads 2, the half-carrier value reads 16 and every compare register reads 0.
- R2: While `run` is high, the reference counter follows 0,1,…,H,H-1,…,1,0,… with H the half-carrier value, so the carrier period is 2H cycles. `cyc_stb` is high for exactly the one cycle in which the reference counter is 0.
- R3: The offset counter always equals the reference counter plus the dead time D. Its upper limit, readable at address 6, is set automatically to D+H.
- R4: One cycle after the counters, the high-side output of a phase is high while the reference counter exceeds its compare value C, and the low-side output is high while the offset counter is at or below C. Over one period this gives 2H-2C-1 high-side cycles and 2(C-D)+1 low-side cycles, for D ≤ C ≤ H-1.
- R5: The two outputs of a phase are never high together. For D ≤ C ≤ H-1, every interval in which both are low lasts exactly D cycles.
- R6: A write to the duty buffer of phase k (address 16+k) does not change that phase's compare register (address 8+k) until the next carrier crest or trough, when the buffered value is taken over.
- R7: A write to the half-carrier buffer (address 2) takes effect only at the next trough. From then on the half-carrier register (address 1) reads the new value, the limit reads D plus the new value, and the period is twice the new value. A value of 0 written to the half-carrier or its buffer is stored as 1.
- R8: With `prot_en` low, writes to the dead time (0), half carrier (1), counters (3, 4), limit (6) and compare registers (8+k) are ignored, and reads of them return 0. The buffers (2, 16+k) and the subcounter (5) stay readable, and the buffers stay writable.
- R9: Writes to the dead time or the half-carrier register take effect only while `run` is low. While running they are ignored.
- R10: The subcounter (address 5) is loaded with D in the cycle any phase output falls, then counts down by one per cycle to 0. It reads 0 while stopped, and bus writes to it have no effect.
- R11: While `run` is low, all outputs are low, the offset counter holds D and the reference counter holds 0.
- R12: With `prot_en` high, a write to a compare register is readable on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Counters run while high, preset while low |
| prot_en | input | 1 | Opens the protected registers to the bus |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data, combinational from address |
| pwm_p | output | NPH | High-side phase outputs |
| pwm_n | output | NPH | Low-side phase outputs |
| cyc_stb | output | 1 | One-cycle strobe at each carrier trough |

## Verification
A corrupted counter or a lost lockstep between the two counters shows up as a wrong gap length or an overlap on the phase outputs within one carrier period. A compare or buffer value that moves at the wrong time shows as a changed high-time count in the period where it should not yet apply. A half-carrier value that moves at the wrong time shows as a wrong spacing of `cyc_stb`. Masking faults are seen at once as a nonzero read while locked, or as a changed readback once access is reopened.

// File: rtl/pwm3_pkg.sv
`timescale 1ns/1ps
package pwm3_pkg;
   localparam int ADDR_W = 5;
   localparam int MAX_PH = 8;

   localparam logic [ADDR_W-1:0] A_DEAD = 5'd0;
   localparam logic [ADDR_W-1:0] A_HALF = 5'd1;
   localparam logic [ADDR_W-1:0] A_HBUF = 5'd2;
   localparam logic [ADDR_W-1:0] A_CNTA = 5'd3;
   localparam logic [ADDR_W-1:0] A_CNTB = 5'd4;
   localparam logic [ADDR_W-1:0] A_SUB  = 5'd5;
   localparam logic [ADDR_W-1:0] A_LIMA = 5'd6;
   localparam logic [ADDR_W-1:0] A_CMP0 = 5'd8;
   localparam logic [ADDR_W-1:0] A_BUF0 = 5'd16;

   typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;
endpackage

// File: rtl/pwm3_regs.sv
`timescale 1ns/1ps
module pwm3_regs
   import pwm3_pkg::*;
#(
   parameter int CW       = 16,
   parameter int NPH      = 3,
   parameter int RST_DEAD = 2,
   parameter int RST_HALF = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic                    prot_en,
   input  logic                    wr,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [CW-1:0]           wdata,
   input  logic                    crest,
   input  logic                    trough,
   input  logic [CW-1:0]           cnt_a,
   input  logic [CW-1:0]           cnt_b,
   input  logic [CW-1:0]           sub,
   output logic [CW-1:0]           rdata,
   output logic [CW-1:0]           dead_o,
   output logic [CW-1:0]           half_o,
   output logic [CW-1:0]           lim_o,
   output logic [NPH-1:0][CW-1:0]  cmp_o,
   output logic [NPH-1:0][CW-1:0]  buf_o
);
   localparam logic [CW-1:0] RST_D = CW'(RST_DEAD);
   localparam logic [CW-1:0] RST_H = CW'(RST_HALF);

   logic [CW-1:0] dead_q, half_q, lim_q, hbuf_q, htmp_q;
   logic          hpend_q;
   logic [CW-1:0] wnz;
   logic          wr_dead, wr_half, wr_hbuf;

   assign wnz     = (wdata == '0) ? CW'(1) : wdata;
   assign wr_dead = wr & prot_en & ~run & (addr == A_DEAD);
   assign wr_half = wr & prot_en & ~run & (addr == A_HALF);
   assign wr_hbuf = wr & (addr == A_HBUF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dead_q  <= RST_D;
         half_q  <= RST_H;
         lim_q   <= RST_D + RST_H;
         hbuf_q  <= RST_H;
         htmp_q  <= RST_H;
         hpend_q <= 1'b0;
      end else begin
         if (trough && hpend_q) begin
            half_q  <= htmp_q;
            lim_q   <= dead_q + htmp_q;
            hpend_q <= 1'b0;
         end
         if (wr_dead) begin
            dead_q <= wdata;
            lim_q  <= wdata + half_q;
         end
         if (wr_half) begin
            half_q <= wnz;
            lim_q  <= dead_q + wnz;
         end
         if (wr_hbuf) begin
            hbuf_q  <= wdata;
            htmp_q  <= wnz;
            hpend_q <= 1'b1;
         end
      end
   end

   for (genvar i = 0; i < NPH; i++) begin : g_ph
      logic [CW-1:0] c_q, b_q, t_q;
      logic          p_q;
      logic          wr_c, wr_b;

      assign wr_c = wr & prot_en & (addr == (A_CMP0 + ADDR_W'(i)));
      assign wr_b = wr & (addr == (A_BUF0 + ADDR_W'(i)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            c_q <= '0;
            b_q <= '0;
            t_q <= '0;
            p_q <= 1'b0;
         end else begin
            if ((crest || trough) && p_q) begin
               c_q <= t_q;
               p_q <= 1'b0;
            end
            if (wr_c) c_q <= wdata;
            if (wr_b) begin
               b_q <= wdata;
               t_q <= wdata;
               p_q <= 1'b1;
            end
         end
      end

      assign cmp_o[i] = c_q;
      assign buf_o[i] = b_q;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_DEAD:  if (prot_en) rdata = dead_q;
         A_HALF:  if (prot_en) rdata = half_q;
         A_HBUF:  rdata = hbuf_q;
         A_CNTA:  if (prot_en) rdata = cnt_a;
         A_CNTB:  if (prot_en) rdata = cnt_b;
         A_SUB:   rdata = sub;
         A_LIMA:  if (prot_en) rdata = lim_q;
         default: begin
            for (int k = 0; k < NPH; k++) begin
               if (prot_en && addr == (A_CMP0 + ADDR_W'(k))) rdata = cmp_o[k];
               if (addr == (A_BUF0 + ADDR_W'(k)))            rdata = buf_o[k];
            end
         end
      endcase
   end

   assign dead_o = dead_q;
   assign half_o = half_q;
   assign lim_o  = lim_q;
endmodule

// File: rtl/pwm3_carrier.sv
`timescale 1ns/1ps
module pwm3_carrier
   import pwm3_pkg::*;
#(
   parameter int CW    = 16,
   parameter int RST_A = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [CW-1:0] dead,
   input  logic [CW-1:0] half,
   input  logic [CW-1:0] lim,
   output logic [CW-1:0] cnt_a,
   output logic [CW-1:0] cnt_b,
   output logic          crest,
   output logic          trough
);
   dir_e dir_a, dir_b;

   // reference counter: 0 .. half .. 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_b <= '0;
         dir_b <= DIR_UP;
      end else if (!run) begin
         cnt_b <= '0;
         dir_b <= DIR_UP;
      end else if (dir_b == DIR_UP) begin
         if (cnt_b >= half) begin
            dir_b <= DIR_DN;
            cnt_b <= cnt_b - 1'b1;
         end else begin
            cnt_b <= cnt_b + 1'b1;
         end
      end else begin
         if (cnt_b == '0) begin
            dir_b <= DIR_UP;
            cnt_b <= cnt_b + 1'b1;
         end else begin
            cnt_b <= cnt_b - 1'b1;
         end
      end
   end

   // offset counter: dead .. dead+half .. dead, own limit and floor
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_a <= CW'(RST_A);
         dir_a <= DIR_UP;
      end else if (!run) begin
         cnt_a <= dead;
         dir_a <= DIR_UP;
      end else if (dir_a == DIR_UP) begin
         if (cnt_a >= lim) begin
            dir_a <= DIR_DN;
            cnt_a <= cnt_a - 1'b1;
         end else begin
            cnt_a <= cnt_a + 1'b1;
         end
      end else begin
         if (cnt_a <= dead) begin
            dir_a <= DIR_UP;
            cnt_a <= cnt_a + 1'b1;
         end else begin
            cnt_a <= cnt_a - 1'b1;
         end
      end
   end

   assign crest  = run & (dir_b == DIR_UP) & (cnt_b >= half);
   assign trough = run & (cnt_b == '0);
endmodule

// File: rtl/pwm3_phase.sv
`timescale 1ns/1ps
module pwm3_phase #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [CW-1:0] cnt_a,
   input  logic [CW-1:0] cnt_b,
   input  logic [CW-1:0] cmp,
   output logic          hi_o,
   output logic          lo_o,
   output logic          fall_o
);
   logic hi_d, lo_d;

   assign hi_d = run & (cnt_b > cmp);
   assign lo_d = run & (cnt_a <= cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_o <= 1'b0;
         lo_o <= 1'b0;
      end else begin
         hi_o <= hi_d;
         lo_o <= lo_d;
      end
   end

   assign fall_o = (hi_o & ~hi_d) | (lo_o & ~lo_d);
endmodule

// File: rtl/pwm3_subcnt.sv
`timescale 1ns/1ps
module pwm3_subcnt #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          load,
   input  logic [CW-1:0] dead,
   output logic [CW-1:0] sub_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            sub_o <= '0;
      else if (!run)         sub_o <= '0;
      else if (load)         sub_o <= dead;
      else if (sub_o != '0)  sub_o <= sub_o - 1'b1;
   end
endmodule

// File: rtl/tri_pwm_deadtime.sv
`timescale 1ns/1ps
module tri_pwm_deadtime
   import pwm3_pkg::*;
#(
   parameter int CW       = 16,
   parameter int NPH      = 3,
   parameter int RST_DEAD = 2,
   parameter int RST_HALF = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              prot_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CW-1:0]     bus_wdata,
   output logic [CW-1:0]     bus_rdata,
   output logic [NPH-1:0]    pwm_p,
   output logic [NPH-1:0]    pwm_n,
   output logic              cyc_stb
);
   initial begin
      assert (CW >= 4 && CW <= 32) else $error("CW out of range");
      assert (NPH >= 1 && NPH <= MAX_PH) else $error("NPH out of range");
      assert (RST_HALF >= 1) else $error("RST_HALF must be nonzero");
      assert (RST_DEAD + RST_HALF < (1 << CW)) else $error("reset limit overflows CW");
   end

   logic [CW-1:0]          cnt_a, cnt_b;
   logic [CW-1:0]          dead_w, half_w, lim_w, sub_w;
   logic [NPH-1:0][CW-1:0] cmp_w, buf_w;
   logic [NPH-1:0]         fall_w;
   logic                   crest, trough;

   pwm3_regs #(.CW(CW), .NPH(NPH), .RST_DEAD(RST_DEAD), .RST_HALF(RST_HALF)) u_regs (
      .clk(clk), .rst_n(rst_n), .run(run), .prot_en(prot_en),
      .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .crest(crest), .trough(trough),
      .cnt_a(cnt_a), .cnt_b(cnt_b), .sub(sub_w),
      .rdata(bus_rdata), .dead_o(dead_w), .half_o(half_w), .lim_o(lim_w),
      .cmp_o(cmp_w), .buf_o(buf_w)
   );

   pwm3_carrier #(.CW(CW), .RST_A(RST_DEAD)) u_car (
      .clk(clk), .rst_n(rst_n), .run(run),
      .dead(dead_w), .half(half_w), .lim(lim_w),
      .cnt_a(cnt_a), .cnt_b(cnt_b), .crest(crest), .trough(trough)
   );

   for (genvar i = 0; i < NPH; i++) begin : g_phase
      pwm3_phase #(.CW(CW)) u_ph (
         .clk(clk), .rst_n(rst_n), .run(run),
         .cnt_a(cnt_a), .cnt_b(cnt_b), .cmp(cmp_w[i]),
         .hi_o(pwm_p[i]), .lo_o(pwm_n[i]), .fall_o(fall_w[i])
      );
   end

   pwm3_subcnt #(.CW(CW)) u_sub (
      .clk(clk), .rst_n(rst_n), .run(run),
      .load(|fall_w), .dead(dead_w), .sub_o(sub_w)
   );

   assign cyc_stb = trough;
endmodule

// File: rtl/pwm3_chk.sv
`timescale 1ns/1ps
module pwm3_chk
   import pwm3_pkg::*;
#(
   parameter int CW  = 16,
   parameter int NPH = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic              prot_en,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [NPH-1:0]    pwm_p,
   input logic [NPH-1:0]    pwm_n,
   input logic              cyc_stb,
   input logic [CW-1:0]     cnt_a,
   input logic [CW-1:0]     cnt_b,
   input logic [CW-1:0]     dead,
   input logic [CW-1:0]     half,
   input logic [CW-1:0]     sub
);
   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) (pwm_p & pwm_n) == '0) else $error("overlap"); // R5
   AST_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n) (run && $past(run)) |-> (cnt_a == cnt_b + dead)) else $error("lockstep"); // R3
   AST_REF_CEIL: assert property (@(posedge clk) disable iff (!rst_n) run |-> (cnt_b <= half)) else $error("ceiling"); // R2
   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) cyc_stb |=> !cyc_stb) else $error("strobe width"); // R2
   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !run |=> (pwm_p == '0 && pwm_n == '0)) else $error("stop quiet"); // R11
   AST_LOCKED_DEAD: assert property (@(posedge clk) disable iff (!rst_n) (!prot_en && bus_wr && bus_addr == A_DEAD) |=> $stable(dead)) else $error("lock"); // R8
   AST_RUN_DEAD: assert property (@(posedge clk) disable iff (!rst_n) run |=> $stable(dead)) else $error("dead while run"); // R9
   AST_HALF_AT_TROUGH: assert property (@(posedge clk) disable iff (!rst_n) (run && !cyc_stb) |=> $stable(half)) else $error("half moved"); // R7
   AST_SUB_BOUND: assert property (@(posedge clk) disable iff (!rst_n) sub <= dead) else $error("sub bound"); // R10
endmodule

bind tri_pwm_deadtime pwm3_chk #(.CW(CW), .NPH(NPH)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .prot_en(prot_en),
   .bus_wr(bus_wr), .bus_addr(bus_addr),
   .pwm_p(pwm_p), .pwm_n(pwm_n), .cyc_stb(cyc_stb),
   .cnt_a(cnt_a), .cnt_b(cnt_b), .dead(dead_w), .half(half_w), .sub(sub_w)
);

// File: tb/tri_pwm_deadtime_test.sv
`timescale 1ns/1ps
module tri_pwm_deadtime_test;
   import pwm3_pkg::*;
   localparam int CW  = 16;
   localparam int NPH = 3;
   localparam int D   = 4;
   localparam int H   = 20;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              run = 1'b0;
   logic              prot_en = 1'b1;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [CW-1:0]     bus_wdata = '0;
   logic [CW-1:0]     bus_rdata;
   logic [NPH-1:0]    pwm_p, pwm_n;
   logic              cyc_stb;

   int n_vec = 0;
   int n_bad = 0;
   int cmpv[NPH];

   always #2.5 clk = ~clk;

   tri_pwm_deadtime #(.CW(CW), .NPH(NPH)) uut (
      .clk(clk), .rst_n(rst_n), .run(run), .prot_en(prot_en),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .pwm_p(pwm_p), .pwm_n(pwm_n), .cyc_stb(cyc_stb)
   );

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [ADDR_W-1:0] a, input int d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = CW'(d);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [ADDR_W-1:0] a, output int v);
      bus_addr = a;
      #1;
      v = int'(bus_rdata);
   endtask

   task automatic wait_stb();
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (cyc_stb) break;
      end
   endtask

   task automatic stb_gap(output int n);
      n = 0;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         n++;
         if (cyc_stb) break;
      end
   endtask

   task automatic t_reset();
      int v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 pwm_p", int'(pwm_p), 0);
      check("R1 pwm_n", int'(pwm_n), 0);
      check("R1 cyc_stb", int'(cyc_stb), 0);
      bus_read(A_DEAD, v); check("R1 dead", v, 2);
      bus_read(A_HALF, v); check("R1 half", v, 16);
      bus_read(A_CMP0, v); check("R1 cmp0", v, 0);
   endtask

   task automatic t_setup();
      int v;
      cmpv[0] = 8; cmpv[1] = 12; cmpv[2] = 16;
      bus_write(A_DEAD, D);
      bus_write(A_HALF, H);
      for (int i = 0; i < NPH; i++) bus_write(A_CMP0 + ADDR_W'(i), cmpv[i]);
      bus_read(A_CMP1_ADDR(), v); check("R12 cmp1 readback", v, 12);
      bus_read(A_LIMA, v); check("R3 limit", v, D + H);
      @(negedge clk);
      bus_read(A_CNTA, v); check("R11 offset preset", v, D);
      bus_read(A_CNTB, v); check("R11 ref preset", v, 0);
   endtask

   function automatic logic [ADDR_W-1:0] A_CMP1_ADDR();
      return A_CMP0 + ADDR_W'(1);
   endfunction

   task automatic measure(input string tag);
      int hp[NPH], hn[NPH], lr[NPH], both;
      for (int i = 0; i < NPH; i++) begin hp[i] = 0; hn[i] = 0; lr[i] = -1; end
      both = 0;
      for (int c = 0; c < 2 * 2 * H; c++) begin
         @(negedge clk);
         for (int i = 0; i < NPH; i++) begin
            if (c < 2 * H) begin
               hp[i] += int'(pwm_p[i]);
               hn[i] += int'(pwm_n[i]);
            end
            if (pwm_p[i] && pwm_n[i]) both++;
            if (!pwm_p[i] && !pwm_n[i]) begin
               if (lr[i] >= 0) lr[i]++;
            end else begin
               if (lr[i] > 0) check({"R5 gap ", tag}, lr[i], D);
               lr[i] = 0;
            end
         end
      end
      check({"R5 both high ", tag}, both, 0);
      for (int i = 0; i < NPH; i++) begin
         check({"R4 high-side count ", tag}, hp[i], 2 * H - 2 * cmpv[i] - 1);
         check({"R4 low-side count ", tag}, hn[i], 2 * (cmpv[i] - D) + 1);
      end
   endtask

   task automatic t_duty();
      int n;
      run = 1'b1;
      repeat (100) @(negedge clk);
      measure("base");
      wait_stb();
      stb_gap(n);
      check("R2 period", n, 2 * H);
   endtask

   task automatic t_buffer();
      int v;
      wait_stb();
      bus_write(A_BUF0, 12);
      bus_read(A_CMP0, v); check("R6 cmp0 before turn", v, 8);
      bus_read(A_BUF0, v); check("R6 buf0 readback", v, 12);
      repeat (45) @(negedge clk);
      bus_read(A_CMP0, v); check("R6 cmp0 after turn", v, 12);
      cmpv[0] = 12;
      measure("after buffer");
   endtask

   task automatic t_halfbuf();
      int v, n;
      wait_stb();
      repeat (3) @(negedge clk);
      bus_write(A_HBUF, 16);
      bus_read(A_HALF, v); check("R7 half before trough", v, H);
      wait_stb();
      stb_gap(n);
      check("R7 new period", n, 32);
      bus_read(A_HALF, v); check("R7 half after trough", v, 16);
      bus_read(A_LIMA, v); check("R7 limit after trough", v, D + 16);
      bus_write(A_HBUF, H);
      wait_stb();
      wait_stb();
      stb_gap(n);
      check("R7 period restored", n, 2 * H);
   endtask

   task automatic t_mask();
      int v;
      prot_en = 1'b0;
      bus_write(A_CMP0, 5);
      bus_read(A_CMP0, v); check("R8 locked read cmp0", v, 0);
      bus_read(A_CNTA, v); check("R8 locked read counter", v, 0);
      bus_read(A_BUF0, v); check("R8 buffer readable", v, 12);
      prot_en = 1'b1;
      bus_read(A_CMP0, v); check("R8 cmp0 kept", v, 12);
      prot_en = 1'b0;
      bus_write(A_BUF0 + ADDR_W'(1), 14);
      prot_en = 1'b1;
      repeat (45) @(negedge clk);
      bus_read(A_CMP0 + ADDR_W'(1), v); check("R8 locked buffer write lands", v, 14);
      cmpv[1] = 14;
   endtask

   task automatic t_runlock();
      int v;
      bus_write(A_DEAD, 7);
      bus_read(A_DEAD, v); check("R9 dead write while running", v, D);
      bus_write(A_HALF, 30);
      bus_read(A_HALF, v); check("R9 half write while running", v, H);
   endtask

   task automatic t_sub();
      logic prev;
      bit   seen;
      prev = 1'b0;
      seen = 1'b0;
      bus_addr = A_SUB;
      for (int k = 0; k < 200 && !seen; k++) begin
         @(negedge clk);
         #1;
         if (prev && !pwm_p[0]) begin
            seen = 1'b1;
            check("R10 sub at fall", int'(bus_rdata), D);
            @(negedge clk);
            #1;
            check("R10 sub next cycle", int'(bus_rdata), D - 1);
         end
         prev = pwm_p[0];
      end
      check("R10 fall seen", int'(seen), 1);
   endtask

   task automatic t_stop();
      int v;
      run = 1'b0;
      bus_write(A_SUB, 9);
      @(negedge clk);
      check("R11 pwm_p stopped", int'(pwm_p), 0);
      check("R11 pwm_n stopped", int'(pwm_n), 0);
      check("R11 strobe stopped", int'(cyc_stb), 0);
      bus_read(A_CNTA, v); check("R11 offset stopped", v, D);
      bus_read(A_CNTB, v); check("R11 ref stopped", v, 0);
      bus_read(A_SUB, v);  check("R10 sub stopped, write ignored", v, 0);
      prot_en = 1'b0;
      bus_write(A_DEAD, 9);
      prot_en = 1'b1;
      bus_read(A_DEAD, v); check("R8 locked dead write", v, D);
      bus_write(A_DEAD, 6);
      bus_read(A_DEAD, v); check("R9 dead write while stopped", v, 6);
      bus_read(A_LIMA, v); check("R3 limit follows dead", v, 6 + H);
   endtask

   initial begin
      t_reset();
      t_setup();
      t_duty();
      t_buffer();
      t_halfbuf();
      t_mask();
      t_runlock();
      t_sub();
      t_stop();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #750000;
      n_vec++;
      n_bad++;
      $display("FAIL R2 watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule